// File: doc/BRIEF.md
# Floating-Point NaN Classifier and Quieter

This unit inspects one packed floating-point operand per cycle in half, bfloat16, single or double format and reports whether it is a quiet NaN or a signaling NaN. Alongside the classification it returns a quieted copy of the operand and the canonical default NaN of the selected format. Execution pipelines use it ahead of their arithmetic to raise the invalid flag and to choose the NaN they propagate.

Two run-time controls shape the result. `sig_pol` chooses which value of the top fraction bit marks a signaling NaN, and that choice also changes how quieting works and what the default NaN looks like. `no_snan` makes the unit treat every NaN as quiet. Results are registered and appear one cycle after an operand is accepted.

Top module: `nanq_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `is_qnan`, `is_snan`, `quieted` and `default_nan` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `in_valid` is low, every result output keeps its value.
- R3: `format` encodes 0 = half (sign 15, exponent 14:10, fraction 9:0), 1 = bfloat16 (sign 15, exponent 14:7, fraction 6:0), 2 = single (sign 31, exponent 30:23, fraction 22:0), 3 = double (sign 63, exponent 62:52, fraction 51:0). Operand bits above the format width have no effect, and those bits are zero in `quieted` and `default_nan`.
- R4: With `sig_pol` = 0 and `no_snan` = 0, an all-ones exponent with the top fraction bit set is a quiet NaN. An all-ones exponent with the top fraction bit clear and some lower fraction bit set is a signaling NaN.
- R5: With `sig_pol` = 1 and `no_snan` = 0, an all-ones exponent with the top fraction bit set is a signaling NaN. An all-ones exponent with the top fraction bit clear and some lower fraction bit set is a quiet NaN.
- R6: With `no_snan` = 1, every NaN is reported as quiet, whatever `sig_pol` is, and `is_snan` is 0.
- R7: An infinity (all-ones exponent, zero fraction) and every value whose exponent is not all ones give `is_qnan` = 0 and `is_snan` = 0.
- R8: With `sig_pol` = 0, a signaling NaN is quieted by setting the top fraction bit. Sign, exponent and the other fraction bits are kept.
- R9: With `sig_pol` = 1, a signaling NaN is quieted by clearing the top fraction bit and setting the bit below it. The other bits are kept.
- R10: An operand that is not reported as a signaling NaN comes out on `quieted` unchanged, apart from the bits cleared by R3.
- R11: `default_nan` has sign 0 and an all-ones exponent. Its fraction is only the top bit when `sig_pol` = 0, and every bit except the top bit when `sig_pol` = 1.
- R12: `is_qnan` and `is_snan` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand accepted this cycle |
| format | input | 2 | Operand format (encoding in R3) |
| operand | input | 64 | Right-aligned packed operand |
| sig_pol | input | 1 | 1: top fraction bit set means signaling |
| no_snan | input | 1 | 1: treat every NaN as quiet |
| out_valid | output | 1 | Results valid this cycle |
| is_qnan | output | 1 | Operand is a quiet NaN |
| is_snan | output | 1 | Operand is a signaling NaN |
| quieted | output | 64 | Operand with a signaling NaN made quiet |
| default_nan | output | 64 | Default NaN of the format and polarity |

## Verification
In every result cycle the classification and the quieting transform act on the same operand, and the polarity input changes both at once. A signaling NaN therefore has to raise `is_snan` and come out rewritten on `quieted` in the same cycle. The bench provokes this with back-to-back operands that flip `sig_pol` between cycles, so a stale polarity in either path shows up. Each result is judged against a scoreboard entry computed from field widths: both flags, the rewritten word and the default pattern are compared together in that one cycle.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

  localparam int DATA_W  = 64;
  localparam int NUM_FMT = 4;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_BF16   = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_DOUBLE = 2'd3
  } nanq_fmt_e;

  typedef struct packed {
    logic              qnan;
    logic              snan;
    logic [DATA_W-1:0] quiet;
    logic [DATA_W-1:0] dflt;
  } nanq_res_t;

  function automatic int fmt_exp_w(input int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      2:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_frac_w(input int idx);
    case (idx)
      0:       return 10;
      1:       return 7;
      2:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/nanq_lane.sv
module nanq_lane
  import nanq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic              sig_pol,
  input  logic              no_snan,
  output nanq_res_t         res
);

  logic              sign_b;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              top_b;
  logic              low_nz;
  logic              any_nan;
  logic              sig_hit;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] frac_d;

  assign {sign_b, exp_f, frac_f} = word;
  assign exp_ones = &exp_f;
  assign top_b    = frac_f[FRAC_W-1];
  assign low_nz   = |frac_f[FRAC_W-2:0];
  assign any_nan  = exp_ones & (top_b | low_nz);

  // Signaling test depends on which polarity marks the top bit.
  assign sig_hit = ~no_snan & exp_ones & (sig_pol ? top_b : (~top_b & low_nz));

  always_comb begin
    if (sig_pol) begin
      frac_q = {2'b01, frac_f[FRAC_W-3:0]};
      frac_d = {1'b0, {(FRAC_W-1){1'b1}}};
    end else begin
      frac_q = {1'b1, frac_f[FRAC_W-2:0]};
      frac_d = {1'b1, {(FRAC_W-1){1'b0}}};
    end
  end

  always_comb begin
    res       = '0;
    res.snan  = sig_hit;
    res.qnan  = any_nan & ~sig_hit;
    res.quiet[WORD_W-1:0] = sig_hit ? {sign_b, exp_f, frac_q} : word;
    res.dflt[WORD_W-1:0]  = {1'b0, {EXP_W{1'b1}}, frac_d};
  end

endmodule

// File: rtl/nanq_stage.sv
module nanq_stage
  import nanq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  nanq_res_t d,
  output nanq_res_t q,
  output logic      vld
);

  nanq_res_t res_nxt;

  always_comb begin
    res_nxt = q;
    if (en) res_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      q   <= res_nxt;
      vld <= en;
    end
  end

endmodule

// File: rtl/nanq_unit.sv
module nanq_unit
  import nanq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  format,
  input  logic [63:0] operand,
  input  logic        sig_pol,
  input  logic        no_snan,
  output logic        out_valid,
  output logic        is_qnan,
  output logic        is_snan,
  output logic [63:0] quieted,
  output logic [63:0] default_nan
);

  nanq_res_t lane_res [NUM_FMT];
  nanq_res_t sel_res;
  nanq_res_t reg_res;

  for (genvar gi = 0; gi < NUM_FMT; gi++) begin : g_lane
    localparam int EW = fmt_exp_w(gi);
    localparam int FW = fmt_frac_w(gi);
    localparam int WW = 1 + EW + FW;
    nanq_lane #(.EXP_W(EW), .FRAC_W(FW)) u_lane (
      .word    (operand[WW-1:0]),
      .sig_pol (sig_pol),
      .no_snan (no_snan),
      .res     (lane_res[gi])
    );
  end

  assign sel_res = lane_res[format];

  nanq_stage u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_valid),
    .d     (sel_res),
    .q     (reg_res),
    .vld   (out_valid)
  );

  assign is_qnan     = reg_res.qnan;
  assign is_snan     = reg_res.snan;
  assign quieted     = reg_res.quiet;
  assign default_nan = reg_res.dflt;

endmodule

// File: rtl/nanq_unit_chk.sv
module nanq_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  format,
  input logic [63:0] operand,
  input logic        sig_pol,
  input logic        no_snan,
  input logic        out_valid,
  input logic        is_qnan,
  input logic        is_snan,
  input logic [63:0] quieted,
  input logic [63:0] default_nan
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(quieted) && $stable(default_nan) && $stable(is_qnan) && $stable(is_snan)));

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_qnan && is_snan));

  a_r6_no_snan_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && no_snan) |=> !is_snan);

  a_r8_single_quiet_pol0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !no_snan && !sig_pol && format == 2'd2 &&
     operand[30:22] == 9'h1FE && operand[21:0] != 22'd0)
    |=> (is_snan && quieted[22] && quieted[30:23] == 8'hFF));

  a_r7_half_infinity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && format == 2'd0 && operand[14:0] == 15'h7C00) |=> (!is_qnan && !is_snan));

endmodule

bind nanq_unit nanq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .format(format),
  .operand(operand), .sig_pol(sig_pol), .no_snan(no_snan),
  .out_valid(out_valid), .is_qnan(is_qnan), .is_snan(is_snan),
  .quieted(quieted), .default_nan(default_nan)
);

// File: tb/nanq_unit_bench.sv
`timescale 1ns/1ps
module nanq_unit_bench;

  typedef struct {
    logic        q;
    logic        s;
    logic [63:0] quiet;
    logic [63:0] dflt;
    string       tag;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  format;
  logic [63:0] operand;
  logic        sig_pol;
  logic        no_snan;
  logic        out_valid;
  logic        is_qnan;
  logic        is_snan;
  logic [63:0] quieted;
  logic [63:0] default_nan;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;
  exp_item_t sb[$];

  always #4 clk = ~clk;

  nanq_unit u_nanq_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .format(format),
    .operand(operand), .sig_pol(sig_pol), .no_snan(no_snan),
    .out_valid(out_valid), .is_qnan(is_qnan), .is_snan(is_snan),
    .quieted(quieted), .default_nan(default_nan)
  );

  task automatic check64(string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic exp_item_t model(logic [1:0] f, logic [63:0] op, logic pol, logic ns, string tag);
    exp_item_t e;
    int ew, fw;
    logic [63:0] v, expf, frac, one, topm;
    logic allones, topb, nan;
    case (f)
      2'd0: begin ew = 5;  fw = 10; end
      2'd1: begin ew = 8;  fw = 7;  end
      2'd2: begin ew = 8;  fw = 23; end
      default: begin ew = 11; fw = 52; end
    endcase
    one  = 64'd1;
    v    = (1 + ew + fw == 64) ? op : (op & ((one << (1 + ew + fw)) - 1));
    expf = (v >> fw) & ((one << ew) - 1);
    frac = v & ((one << fw) - 1);
    topm = one << (fw - 1);
    allones = (expf == ((one << ew) - 1));
    topb = (frac & topm) != 0;
    nan  = allones && (frac != 0);
    if (ns) begin
      e.q = nan; e.s = 1'b0;
    end else if (!pol) begin
      e.q = nan && topb;  e.s = nan && !topb;
    end else begin
      e.q = nan && !topb; e.s = nan && topb;
    end
    if (e.s) e.quiet = pol ? ((v & ~topm) | (topm >> 1)) : (v | topm);
    else     e.quiet = v;
    e.dflt = (((one << ew) - 1) << fw) | (pol ? (topm - 1) : topm);
    e.tag  = tag;
    return e;
  endfunction

  task automatic send(logic [1:0] f, logic [63:0] op, logic pol, logic ns, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    format   = f;
    operand  = op;
    sig_pol  = pol;
    no_snan  = ns;
    sb.push_back(model(f, op, pol, ns, tag));
  endtask

  task automatic idle_and_hold(string tag);
    logic [63:0] q0, d0;
    @(negedge clk);
    in_valid = 1'b0;
    operand  = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    q0 = quieted; d0 = default_nan;
    @(negedge clk);
    @(negedge clk);
    check64(tag, "out_valid idle", {63'd0, out_valid}, 64'd0);
    check64(tag, "quieted held", quieted, q0);
    check64(tag, "default_nan held", default_nan, d0);
  endtask

  // Monitor: pops one expected item per valid result.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (sb.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
      end else begin
        exp_item_t e;
        e = sb.pop_front();
        check64(e.tag, "is_qnan", {63'd0, is_qnan}, {63'd0, e.q});
        check64(e.tag, "is_snan", {63'd0, is_snan}, {63'd0, e.s});
        check64(e.tag, "quieted", quieted, e.quiet);
        check64(e.tag, "default_nan", default_nan, e.dflt);
      end
    end
  end

  initial begin
    in_valid = 1'b0; format = 2'd0; operand = 64'd0; sig_pol = 1'b0; no_snan = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check64("R1", "out_valid", {63'd0, out_valid}, 64'd0);
    check64("R1", "flags", {62'd0, is_qnan, is_snan}, 64'd0);
    check64("R1", "quieted", quieted, 64'd0);
    check64("R1", "default_nan", default_nan, 64'd0);
    rst_n = 1'b1;

    // polarity 0 classification and quieting
    send(2'd0, 64'h7E00, 0, 0, "R4 half qnan");
    send(2'd0, 64'h7C01, 0, 0, "R4 R8 half snan");
    send(2'd0, 64'h7C00, 0, 0, "R7 half inf");
    send(2'd0, 64'h3C00, 0, 0, "R7 R10 half normal");
    send(2'd1, 64'h7FC0, 0, 0, "R4 bf16 qnan");
    send(2'd1, 64'hFF81, 0, 0, "R4 R8 bf16 snan neg");
    send(2'd1, 64'h7F80, 0, 0, "R7 bf16 inf");
    send(2'd2, 64'h7FC0_0000, 0, 0, "R4 R10 single qnan");
    send(2'd2, 64'h7F80_0001, 0, 0, "R8 single snan");
    send(2'd2, 64'hFF80_0000, 0, 0, "R7 single neg inf");
    send(2'd3, 64'h7FF8_0000_0000_0000, 0, 0, "R4 double qnan");
    send(2'd3, 64'hFFF0_0000_0000_0001, 0, 0, "R8 double snan");
    send(2'd3, 64'h7FF0_0000_0000_0000, 0, 0, "R7 double inf");
    idle_and_hold("R2 hold");

    // polarity 1, back to back with polarity flips
    send(2'd2, 64'h7FC0_0000, 1, 0, "R5 R9 single snan");
    send(2'd2, 64'h7FC0_0000, 0, 0, "R4 single flip back");
    send(2'd2, 64'h7FE0_1234, 1, 0, "R9 single snan next bit set");
    send(2'd2, 64'h7F80_0001, 1, 0, "R5 R10 single qnan");
    send(2'd0, 64'hFE00, 1, 0, "R9 half snan");
    send(2'd1, 64'h7F81, 1, 0, "R5 bf16 qnan");
    send(2'd3, 64'h7FF8_0000_0000_0005, 1, 0, "R9 double snan");
    send(2'd3, 64'h7FF0_0000_0000_0000, 1, 0, "R7 double inf pol1");
    send(2'd1, 64'h7F80, 1, 0, "R11 bf16 default pol1");

    // no-signaling mode
    send(2'd2, 64'h7F80_0001, 0, 1, "R6 R10 single");
    send(2'd2, 64'h7FC0_0000, 1, 1, "R6 single pol1");
    send(2'd0, 64'h7C00, 1, 1, "R6 R7 half inf");

    // upper bits above the format width
    send(2'd0, 64'hDEAD_BEEF_0000_7C01, 0, 0, "R3 half garbage");
    send(2'd1, 64'hFFFF_FFFF_FFFF_3F80, 1, 0, "R3 bf16 garbage");
    send(2'd2, 64'h1234_5678_7F80_0002, 0, 0, "R3 single garbage");
    send(2'd2, 64'h0000_0001_0000_0000, 0, 0, "R3 R12 single zero");
    idle_and_hold("R2 R12 final hold");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R2 missing results: actual %0d left expected 0", sb.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule